// File: doc/BRIEF.md
# Level/Edge Interrupt Pending Tracker

This block keeps the pending and active state for a parameterised group of shared peripheral interrupt lines (32 by default). It selects one of them for service and drives a single interrupt request toward one processor. Each line has a two-bit mode field that makes it level-sensitive or edge-triggered. The raw line inputs pass through a synchroniser. The block then picks the lowest-numbered line that is pending, enabled and not already active, and shows its number on a registered output. When nothing qualifies, the output shows the spurious number 1023.

Software-side actions reach the block as single-cycle strobes:
- An acknowledge takes the current winner and marks it active.
- A pending-clear write drops edge pending bits.
- An active-clear write ends service of a line.
- A mode-word write sets the line modes.

The two line kinds differ in three ways:
- A level-sensitive line's pending state simply follows its synchronised input.
- An edge-triggered line latches a rising edge and keeps it until it is acknowledged or cleared.
- The request output is withdrawn right away when a level-sensitive winner goes away. It is held after an edge-triggered winner until the processor acknowledges.

Top module: `irq_pend_tracker`

## Requirements
- R1: After synchronous reset `hp_id` and `ack_id` read 1023, `irq` is low, every line is level-sensitive, and no line is pending or active.
- R2: Line i owns bits [2*(i%16)+1 : 2*(i%16)] of mode word i/16, written through `cfg_we`/`cfg_idx`/`cfg_wdata`. The upper bit of the pair selects the mode: 1 is edge-triggered, 0 is level-sensitive. The lower bit is ignored.
- R3: An edge-triggered line becomes pending on a rising edge of its input after a 2-stage synchroniser, and stays pending after the input falls.
- R4: A level-sensitive line's pending bit equals its synchronised input. A pending-clear write has no effect on it.
- R5: `hp_id` shows the lowest index that is pending, enabled (`line_en`) and not active, or 1023 when none qualifies. A change on `irq_in` appears on `hp_id` at the fourth rising clock edge.
- R6: On an `ack_req` cycle, `ack_id` takes the current winner at the next edge and the winner's active bit is set. Its pending bit is cleared only if it is edge-triggered. With no winner, `ack_id` becomes 1023 and no pending or active bit changes.
- R7: A pending-clear write (`pend_clr_we` with `pend_clr_mask`) clears the masked edge-triggered pending bits. A rising edge in the same cycle sets the bit again.
- R8: An active-clear write (`act_clr_we` with `act_clr_mask`) clears the masked active bits. An acknowledge of the same line in the same cycle wins.
- R9: `irq` rises at the same edge that `hp_id` takes a valid number. It falls at the next edge once no winner exists, provided the last registered winner was level-sensitive.
- R10: After an edge-triggered winner disappears, `irq` stays high until an `ack_req` is seen. It falls at the edge of that acknowledge, or one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_LINES | Raw interrupt lines |
| line_en | input | N_LINES | Per-line enable for selection |
| cfg_we | input | 1 | Mode word write strobe |
| cfg_idx | input | CFG_IDX_W | Mode word index |
| cfg_wdata | input | 32 | Mode word data, two bits per line |
| pend_clr_we | input | 1 | Pending-clear write strobe |
| pend_clr_mask | input | N_LINES | Lines whose edge pending bit is cleared |
| act_clr_we | input | 1 | Active-clear write strobe |
| act_clr_mask | input | N_LINES | Lines whose active bit is cleared |
| ack_req | input | 1 | Acknowledge strobe |
| ack_id | output | 10 | Number returned by the last acknowledge |
| hp_id | output | 10 | Highest-priority pending number or 1023 |
| irq | output | 1 | Interrupt request toward the processor |

## Verification
The directed cases exercise each line kind and separate the two mode behaviours:
- A single level line rising and falling shows the four-edge latency and the immediate withdrawal of the request.
- A short pulse on an edge line shows that pending is latched, and that the request is held until an acknowledge.
- Two simultaneous level lines show lowest-index priority.
- Acknowledging one of those level lines and then clearing its active bit shows that the acknowledge left its pending state alone.

A seeded random run then toggles sparse lines, modes, enables and both clear masks, and fires acknowledges. It compares every cycle against a cycle model, which reaches same-cycle collisions of clear, rise and acknowledge that the directed cases do not.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int ID_W       = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
  localparam int CFG_DATA_W = 32;
  localparam int FIELD_W    = 2;
  localparam int MODE_BIT   = 1;
  localparam int LINES_PER_WORD = CFG_DATA_W / FIELD_W;
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
  parameter int N_LINES = 32,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] raw,
  output logic [N_LINES-1:0] lvl,
  output logic [N_LINES-1:0] rise
);
  logic [N_LINES-1:0] chain_q [STAGES];
  logic [N_LINES-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      prev_q <= '0;
    end else begin
      chain_q[0] <= raw;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign lvl  = chain_q[STAGES-1];
  assign rise = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/irq_cfg_store.sv
module irq_cfg_store
  import irq_pend_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int IDX_W   = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [IDX_W-1:0]      idx,
  input  logic [CFG_DATA_W-1:0] wdata,
  output logic [N_LINES-1:0]    edge_mode
);
  logic [N_LINES-1:0] mode_q;
  logic               wdata_unused;

  assign wdata_unused = ^wdata;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    localparam int WORD = i / LINES_PER_WORD;
    localparam int POS  = (i % LINES_PER_WORD) * FIELD_W + MODE_BIT;
    always_ff @(posedge clk) begin
      if (rst) mode_q[i] <= 1'b0;
      else if (we && idx == IDX_W'(WORD)) mode_q[i] <= wdata[POS];
    end
  end

  assign edge_mode = mode_q;
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick
  import irq_pend_pkg::*;
#(
  parameter int N_LINES = 32
) (
  input  logic [N_LINES-1:0] cand,
  output logic               valid,
  output logic [ID_W-1:0]    id,
  output logic [N_LINES-1:0] onehot
);
  always_comb begin
    valid = 1'b0;
    id    = SPURIOUS_ID;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (cand[i]) begin
        valid = 1'b1;
        id    = ID_W'(i);
      end
    end
  end

  assign onehot = cand & ~(cand - N_LINES'(1));
endmodule

// File: rtl/irq_pend_tracker.sv
module irq_pend_tracker
  import irq_pend_pkg::*;
#(
  parameter int N_LINES     = 32,
  parameter int SYNC_STAGES = 2,
  localparam int CFG_WORDS  = (N_LINES * FIELD_W + CFG_DATA_W - 1) / CFG_DATA_W,
  localparam int CFG_IDX_W  = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_LINES-1:0]    irq_in,
  input  logic [N_LINES-1:0]    line_en,
  input  logic                  cfg_we,
  input  logic [CFG_IDX_W-1:0]  cfg_idx,
  input  logic [CFG_DATA_W-1:0] cfg_wdata,
  input  logic                  pend_clr_we,
  input  logic [N_LINES-1:0]    pend_clr_mask,
  input  logic                  act_clr_we,
  input  logic [N_LINES-1:0]    act_clr_mask,
  input  logic                  ack_req,
  output logic [ID_W-1:0]       ack_id,
  output logic [ID_W-1:0]       hp_id,
  output logic                  irq
);
  logic [N_LINES-1:0] line_lvl, line_rise, edge_mode;
  logic [N_LINES-1:0] pend_q, act_q, cand, win_onehot, ack_hot;
  logic [N_LINES-1:0] pclr_vec, aclr_vec, pend_nx, act_nx;
  logic               win_valid, hp_level_q, ack_d_q, irq_q, irq_nx;
  logic [ID_W-1:0]    win_id, hp_q, ack_id_q;

  irq_line_sync #(.N_LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw(irq_in), .lvl(line_lvl), .rise(line_rise)
  );

  irq_cfg_store #(.N_LINES(N_LINES), .IDX_W(CFG_IDX_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata),
    .edge_mode(edge_mode)
  );

  assign cand = pend_q & line_en & ~act_q;

  irq_lowest_pick #(.N_LINES(N_LINES)) u_pick (
    .cand(cand), .valid(win_valid), .id(win_id), .onehot(win_onehot)
  );

  assign ack_hot  = ack_req ? win_onehot : '0;
  assign pclr_vec = pend_clr_we ? pend_clr_mask : '0;
  assign aclr_vec = act_clr_we ? act_clr_mask : '0;

  // edge lines latch and are cleared by software or ack; level lines follow input
  assign pend_nx = (edge_mode & ((pend_q & ~pclr_vec & ~ack_hot) | line_rise))
                 | (~edge_mode & line_lvl);
  assign act_nx  = (act_q & ~aclr_vec) | ack_hot;

  // hold the request after an edge winner until the processor acknowledges
  assign irq_nx = win_valid | (irq_q & ~hp_level_q & ~ack_req & ~ack_d_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= '0;
      act_q      <= '0;
      hp_q       <= SPURIOUS_ID;
      hp_level_q <= 1'b0;
      ack_id_q   <= SPURIOUS_ID;
      ack_d_q    <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      pend_q     <= pend_nx;
      act_q      <= act_nx;
      hp_q       <= win_id;
      hp_level_q <= win_valid & |(win_onehot & ~edge_mode);
      ack_d_q    <= ack_req;
      irq_q      <= irq_nx;
      if (ack_req) ack_id_q <= win_id;
    end
  end

  assign ack_id = ack_id_q;
  assign hp_id  = hp_q;
  assign irq    = irq_q;
endmodule

// File: rtl/irq_pend_tracker_chk.sv
module irq_pend_tracker_chk
  import irq_pend_pkg::*;
#(
  parameter int N_LINES = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               ack_req,
  input logic               act_clr_we,
  input logic               win_valid,
  input logic [N_LINES-1:0] win_onehot,
  input logic [N_LINES-1:0] edge_mode,
  input logic [N_LINES-1:0] line_rise,
  input logic [N_LINES-1:0] pend_q,
  input logic [N_LINES-1:0] act_q,
  input logic [ID_W-1:0]    ack_id,
  input logic               irq,
  input logic               hp_level_q
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!irq && ack_id == SPURIOUS_ID && pend_q == '0 && act_q == '0));

  assert_single_winner_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(win_onehot) && (win_valid == (win_onehot != '0)));

  assert_ack_sets_active_R6: assert property (@(posedge clk) disable iff (rst)
    (ack_req && win_valid) |=> ((act_q & $past(win_onehot)) != '0));

  assert_ack_edge_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (ack_req && win_valid && (win_onehot & edge_mode) != '0 && (win_onehot & line_rise) == '0)
    |=> ((pend_q & $past(win_onehot)) == '0));

  assert_spurious_ack_R6: assert property (@(posedge clk) disable iff (rst)
    (ack_req && !win_valid && !act_clr_we) |=> (ack_id == SPURIOUS_ID && $stable(act_q)));

  assert_level_withdraw_R9: assert property (@(posedge clk) disable iff (rst)
    (!win_valid && hp_level_q) |=> !irq);

  assert_irq_needs_winner_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(win_valid));
endmodule

bind irq_pend_tracker irq_pend_tracker_chk #(.N_LINES(N_LINES)) u_chk (
  .clk(clk), .rst(rst), .ack_req(ack_req), .act_clr_we(act_clr_we),
  .win_valid(win_valid), .win_onehot(win_onehot), .edge_mode(edge_mode),
  .line_rise(line_rise), .pend_q(pend_q), .act_q(act_q), .ack_id(ack_id),
  .irq(irq), .hp_level_q(hp_level_q)
);

// File: tb/irq_pend_tracker_bench.sv
`timescale 1ns/1ps
module irq_pend_tracker_bench;
  localparam int N = 32;
  localparam logic [9:0] SPUR = 10'd1023;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] irq_in = '0, line_en = '1, pend_clr_mask = '0, act_clr_mask = '0;
  logic         cfg_we = 1'b0, pend_clr_we = 1'b0, act_clr_we = 1'b0, ack_req = 1'b0;
  logic [0:0]   cfg_idx = '0;
  logic [31:0]  cfg_wdata = '0;
  logic [9:0]   ack_id, hp_id;
  logic         irq;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_pend_tracker #(.N_LINES(N)) u_irq_pend_tracker (
    .clk(clk), .rst(rst), .irq_in(irq_in), .line_en(line_en),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .pend_clr_we(pend_clr_we), .pend_clr_mask(pend_clr_mask),
    .act_clr_we(act_clr_we), .act_clr_mask(act_clr_mask),
    .ack_req(ack_req), .ack_id(ack_id), .hp_id(hp_id), .irq(irq)
  );

  // ---- cycle model built from the requirements ----
  logic [N-1:0] m_s1, m_s2, m_prev, m_edge, m_pend, m_act;
  logic [9:0]   m_hp, m_ackid;
  logic         m_hplvl, m_ackd, m_irq;

  function automatic logic [9:0] f_pick(input logic [N-1:0] c);
    logic [9:0] r = SPUR;
    for (int i = N - 1; i >= 0; i--) if (c[i]) r = 10'(i);
    return r;
  endfunction

  always @(posedge clk) begin
    logic [N-1:0] c, hot, rise, pn;
    logic [9:0]   w;
    if (rst) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_edge <= '0; m_pend <= '0; m_act <= '0;
      m_hp <= SPUR; m_ackid <= SPUR; m_hplvl <= 1'b0; m_ackd <= 1'b0; m_irq <= 1'b0;
    end else begin
      c    = m_pend & line_en & ~m_act;
      w    = f_pick(c);
      hot  = '0;
      if (ack_req && w != SPUR) hot[w[4:0]] = 1'b1;
      rise = m_s2 & ~m_prev;
      for (int i = 0; i < N; i++) begin
        if (m_edge[i])
          pn[i] = (m_pend[i] && !(pend_clr_we && pend_clr_mask[i]) && !hot[i]) || rise[i];
        else
          pn[i] = m_s2[i];
      end
      m_pend <= pn;
      m_act  <= (m_act & ~(act_clr_we ? act_clr_mask : '0)) | hot;
      m_s1 <= irq_in; m_s2 <= m_s1; m_prev <= m_s2;
      if (cfg_we)
        for (int i = 0; i < N; i++)
          if (i / 16 == int'(cfg_idx)) m_edge[i] <= cfg_wdata[(i % 16) * 2 + 1];
      m_hp    <= w;
      m_hplvl <= (w != SPUR) && !m_edge[w[4:0]];
      m_irq   <= (w != SPUR) || (m_irq && !m_hplvl && !ack_req && !m_ackd);
      m_ackd  <= ack_req;
      if (ack_req) m_ackid <= w;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_model();
    check("R5 hp_id vs model", 32'(hp_id), 32'(m_hp));
    check("R9 irq vs model", 32'(irq), 32'(m_irq));
    check("R6 ack_id vs model", 32'(ack_id), 32'(m_ackid));
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic idx, input logic [31:0] d);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d; cyc(1); cfg_we = 1'b0;
  endtask

  task automatic pend_clr(input logic [N-1:0] m);
    pend_clr_we = 1'b1; pend_clr_mask = m; cyc(1); pend_clr_we = 1'b0;
  endtask

  task automatic act_clr(input logic [N-1:0] m);
    act_clr_we = 1'b1; act_clr_mask = m; cyc(1); act_clr_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    cyc(3);
    rst = 1'b0;
    cyc(1);
    check("R1 reset hp_id", 32'(hp_id), 1023);
    check("R1 reset irq", 32'(irq), 0);
    check("R1 reset ack_id", 32'(ack_id), 1023);

    // level line 5: latency and withdrawal
    irq_in[5] = 1'b1;
    cyc(3); check("R5 hp_id before 4th edge", 32'(hp_id), 1023);
    cyc(1); check("R5 hp_id at 4th edge", 32'(hp_id), 5);
    check("R9 irq rises with hp_id", 32'(irq), 1);
    irq_in[5] = 1'b0;
    cyc(4); check("R4 level pending follows input", 32'(hp_id), 1023);
    check("R9 irq withdrawn after level", 32'(irq), 0);

    // edge lines 7 (word0 bit15) and 20 (word1 bit9)
    cfg_write(1'b0, 32'h0000_8000);
    cfg_write(1'b1, 32'h0000_0200);
    irq_in[7] = 1'b1; cyc(2); irq_in[7] = 1'b0;
    cyc(8); check("R3 edge stays pending after fall", 32'(hp_id), 7);
    check("R9 irq on edge winner", 32'(irq), 1);
    pend_clr(32'h1 << 7);
    cyc(2); check("R7 pending clear on edge", 32'(hp_id), 1023);
    check("R10 irq held after edge", 32'(irq), 1);
    ack_req = 1'b1; cyc(1); ack_req = 1'b0;
    check("R6 empty ack returns 1023", 32'(ack_id), 1023);
    check("R10 irq drops on ack", 32'(irq), 0);

    // two level lines 3 and 9
    irq_in[3] = 1'b1; irq_in[9] = 1'b1;
    cyc(6); check("R5 lowest index wins", 32'(hp_id), 3);
    ack_req = 1'b1; cyc(1); ack_req = 1'b0;
    check("R6 ack returns winner", 32'(ack_id), 3);
    cyc(1); check("R6 active line skipped", 32'(hp_id), 9);
    pend_clr(32'h1 << 3);
    act_clr(32'h1 << 3);
    cyc(2); check("R4 R8 level pending kept after ack and clear", 32'(hp_id), 3);
    line_en[3] = 1'b0;
    cyc(2); check("R5 disabled line skipped", 32'(hp_id), 9);
    line_en[3] = 1'b1;
    irq_in[3] = 1'b0; irq_in[9] = 1'b0;
    cyc(6); check("R9 idle after level lines fall", 32'(irq), 0);

    // edge line 20: acknowledge clears pending
    irq_in[20] = 1'b1; cyc(1); irq_in[20] = 1'b0;
    cyc(6); check("R2 word1 edge field", 32'(hp_id), 20);
    ack_req = 1'b1; cyc(1); ack_req = 1'b0;
    check("R6 ack edge line", 32'(ack_id), 20);
    act_clr(32'h1 << 20);
    cyc(3); check("R6 edge pending cleared by ack", 32'(hp_id), 1023);
    check("R10 irq dropped after edge ack", 32'(irq), 0);

    // mode bit 0 alone does not make a line edge-triggered (line 16 -> word1 bit0)
    cfg_write(1'b1, 32'h0000_0001);
    irq_in[16] = 1'b1; cyc(2); irq_in[16] = 1'b0;
    cyc(8); check("R2 low field bit ignored", 32'(hp_id), 1023);

    // random phase against the cycle model
    for (int k = 0; k < 4000; k++) begin
      check_model();
      irq_in  = irq_in ^ ($urandom & $urandom & $urandom & $urandom);
      if ($urandom_range(0, 7) == 0) line_en[$urandom_range(0, N-1)] ^= 1'b1;
      cfg_we = ($urandom_range(0, 63) == 0);
      cfg_idx = 1'($urandom);
      cfg_wdata = $urandom;
      pend_clr_we = ($urandom_range(0, 15) == 0);
      pend_clr_mask = 32'h1 << $urandom_range(0, N-1);
      act_clr_we = ($urandom_range(0, 7) == 0);
      act_clr_mask = $urandom & $urandom;
      ack_req = ($urandom_range(0, 5) == 0);
      cyc(1);
    end
    cfg_we = 1'b0; pend_clr_we = 1'b0; act_clr_we = 1'b0; ack_req = 1'b0;
    check_model();
    finish_run();
  end
endmodule